// File: doc/BRIEF.md
# Two-Channel Playback Command Controller

This block sequences sound playback on two channels, typically a voice channel (channel 0) and a background-music channel (channel 1). Software sets up a channel through a small register bus: a command code, a sentence number, a volume and a repeat count, plus a playback speed on channel 0 only. It then issues the command by writing a shared trigger register, which also names the target channel. Only one command can be in flight at a time. A ready status bit drops while the accepted command is being taken up and rises again once the target channel has moved to its play state.

Each channel runs a two-state machine, `CH_IDLE` (state register reads 0x0001) and `CH_PLAY` (reads 0x0002). The transitions are `START` (idle to play, on an accepted Sound Start command) and `FINISH` (play to idle, when the playback stub has counted out the sentence the requested number of times). A command controller with states `CC_READY` and `CC_WAIT` accepts triggers. Its transitions are `ACCEPT` (ready to wait) and `TAKEN` (wait to ready, once the target reports play). Every channel transition sets one shared sticky interrupt flag, which software clears by writing 0.

The playback stub does not fetch sentence data. While a channel plays, its sample is a fixed amplitude. The sample is scaled by the channel volume and summed with the other channel into a saturated signed 16-bit output.

Top module: `dual_play_ctrl`

## Requirements
- R1: After reset both channel state registers read 0x0001, the trigger register reads 1 in bit 0 (ready), the flag register reads 0, `irq` is 0 and `mix_out` is 0.
- R2: Register map (4-bit word address): channel 0 at 0x0 command (8 bits), 0x1 sentence, 0x2 volume, 0x3 repeat, 0x4 speed, 0x5 state (read-only). Channel 1 at 0x8 command, 0x9 sentence, 0xA volume, 0xB repeat, 0xD state. 0xE is the trigger, 0xF is the flag. Writable fields read back what was written.
- R3: A write to 0xE with bit 0 set issues a command to channel bit 1 (0 or 1). It is accepted only if the controller is ready, the target is idle and its command field holds 0x01 (Sound Start). On acceptance the target state reads 0x0002 in the next cycle.
- R4: A trigger whose target command is not 0x01 has no effect: state, flag and ready are unchanged.
- R5: Reading 0xE returns ready in bit 0. Ready reads 0 for exactly the one cycle after an accepted trigger and 1 again after that.
- R6: A trigger aimed at a channel that is already playing is ignored and sets no flag.
- R7: A started channel plays for (sentence+1)·(repeat+1) sample periods and then returns to idle. A period is speed+1 clock cycles on channel 0 and 4 cycles on channel 1.
- R8: Every idle-to-play and play-to-idle transition sets the flag (bit 0 of 0xF, also driven on `irq`). Writing 0xF with bit 0 = 0 clears it. Writing bit 0 = 1 leaves it unchanged.
- R9: If a transition occurs in the same cycle as a clearing write, the flag stays set.
- R10: Volume may be rewritten during playback, and `mix_out` follows the new value within two cycles.
- R11: Writes to the channel 0 speed register while channel 0 plays are ignored. Writes while it is idle take effect.
- R12: `mix_out` = saturate16(floor(A·vol0/65536)·play0 + floor(A·vol1/65536)·play1), with A = 24576, registered one cycle after state and volume. It is 0 when both channels are idle, and it clips at 32767.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Shared sticky transition flag |
| mix_out | output | 16 | Signed saturated mixed sample |

## Verification
The embedded assertions check the following on every cycle:
- the speed register never changes across consecutive play cycles;
- a start pulse only reaches an idle channel;
- no second start issues while a command is in flight;
- ready falls after every acceptance;
- every transition is followed by a set flag;
- the output is silent after a cycle with both channels idle.

The bench scenarios cover the rest: playback length as a function of sentence, repeat and speed; the arithmetic of the volume-scaled mix and its clipping; the ordering of a clear write against a coinciding end-of-playback event; and the rejection of wrong command codes.

// File: rtl/dual_play_pkg.sv
package dual_play_pkg;
    localparam int REG_W = 16;
    localparam int CMD_W = 8;
    localparam logic [CMD_W-1:0] CMD_SOUND_START = 8'h01;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd1,
        CH_PLAY = 2'd2
    } ch_state_e;

    typedef enum logic {
        CC_READY = 1'b0,
        CC_WAIT  = 1'b1
    } cc_state_e;

    localparam logic [3:0] A_CMD0 = 4'h0;
    localparam logic [3:0] A_SEN0 = 4'h1;
    localparam logic [3:0] A_VOL0 = 4'h2;
    localparam logic [3:0] A_REP0 = 4'h3;
    localparam logic [3:0] A_SPD0 = 4'h4;
    localparam logic [3:0] A_ST0  = 4'h5;
    localparam logic [3:0] A_CMD1 = 4'h8;
    localparam logic [3:0] A_SEN1 = 4'h9;
    localparam logic [3:0] A_VOL1 = 4'hA;
    localparam logic [3:0] A_REP1 = 4'hB;
    localparam logic [3:0] A_SPD1 = 4'hC;
    localparam logic [3:0] A_ST1  = 4'hD;
    localparam logic [3:0] A_GO   = 4'hE;
    localparam logic [3:0] A_FLAG = 4'hF;
endpackage

// File: rtl/play_chan.sv
module play_chan
    import dual_play_pkg::*;
#(
    parameter bit HAS_SPEED    = 1'b1,
    parameter int FIXED_PERIOD = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cmd,
    input  logic             wr_sen,
    input  logic             wr_vol,
    input  logic             wr_rep,
    input  logic             wr_spd,
    input  logic [REG_W-1:0] wdata,
    input  logic             start,
    output logic [CMD_W-1:0] cmd_q,
    output logic [REG_W-1:0] sen_q,
    output logic [REG_W-1:0] vol_q,
    output logic [REG_W-1:0] rep_q,
    output logic [REG_W-1:0] spd_q,
    output ch_state_e        state,
    output logic             evt
);
    localparam logic [REG_W-1:0] FIXED_RELOAD = REG_W'(FIXED_PERIOD - 1);

    ch_state_e        nxt;
    logic [REG_W-1:0] div_cnt, smp_cnt, rpt_cnt, sen_lat;
    logic [REG_W-1:0] reload;
    logic             last;

    assign reload = HAS_SPEED ? spd_q : FIXED_RELOAD;
    assign last   = (div_cnt == '0) && (smp_cnt == '0) && (rpt_cnt == '0);

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
            sen_q <= '0;
            vol_q <= '0;
            rep_q <= '0;
            spd_q <= '0;
        end else begin
            if (wr_cmd) cmd_q <= wdata[CMD_W-1:0];
            if (wr_sen) sen_q <= wdata;
            if (wr_vol) vol_q <= wdata;
            if (wr_rep) rep_q <= wdata;
            if (wr_spd && HAS_SPEED && (state == CH_IDLE)) spd_q <= wdata;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CH_IDLE;
        else        state <= nxt;
    end

    // next state and transition event
    always_comb begin
        nxt = state;
        evt = 1'b0;
        unique case (state)
            CH_IDLE: if (start) begin
                nxt = CH_PLAY;   // START
                evt = 1'b1;
            end
            CH_PLAY: if (last) begin
                nxt = CH_IDLE;   // FINISH
                evt = 1'b1;
            end
            default: nxt = CH_IDLE;
        endcase
    end

    // playback stub counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
            smp_cnt <= '0;
            rpt_cnt <= '0;
            sen_lat <= '0;
        end else if (state == CH_IDLE) begin
            if (start) begin
                div_cnt <= reload;
                smp_cnt <= sen_q;
                rpt_cnt <= rep_q;
                sen_lat <= sen_q;
            end
        end else if (div_cnt == '0) begin
            div_cnt <= reload;
            if (smp_cnt == '0) begin
                if (rpt_cnt != '0) begin
                    rpt_cnt <= rpt_cnt - 1'b1;
                    smp_cnt <= sen_lat;
                end
            end else begin
                smp_cnt <= smp_cnt - 1'b1;
            end
        end else begin
            div_cnt <= div_cnt - 1'b1;
        end
    end

    AST_SPEED_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_PLAY) |=> ((state != CH_PLAY) || $stable(spd_q))); // R11
    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (state == CH_IDLE)); // R6
endmodule

// File: rtl/cmd_ctrl.sv
module cmd_ctrl
    import dual_play_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_wr,
    input  logic             go_sel,
    input  logic             clr_wr,
    input  logic [CMD_W-1:0] cmd0,
    input  logic [CMD_W-1:0] cmd1,
    input  logic             play0,
    input  logic             play1,
    input  logic             evt0,
    input  logic             evt1,
    output logic             start0,
    output logic             start1,
    output logic             ready,
    output logic             flag
);
    cc_state_e cc_state, cc_nxt;
    logic      sel_q;
    logic      tgt_idle, tgt_cmd_ok, accept;

    assign tgt_idle   = go_sel ? !play1 : !play0;
    assign tgt_cmd_ok = (go_sel ? cmd1 : cmd0) == CMD_SOUND_START;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cc_state <= CC_READY;
            sel_q    <= 1'b0;
        end else begin
            cc_state <= cc_nxt;
            if (accept) sel_q <= go_sel;
        end
    end

    always_comb begin
        cc_nxt = cc_state;
        accept = 1'b0;
        unique case (cc_state)
            CC_READY: if (go_wr && tgt_idle && tgt_cmd_ok) begin
                accept = 1'b1;
                cc_nxt = CC_WAIT;    // ACCEPT
            end
            CC_WAIT: if (sel_q ? play1 : play0) cc_nxt = CC_READY; // TAKEN
            default: cc_nxt = CC_READY;
        endcase
    end

    always_comb begin
        start0 = accept && !go_sel;
        start1 = accept && go_sel;
        ready  = (cc_state == CC_READY);
    end

    // sticky flag: a transition event wins over a clearing write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             flag <= 1'b0;
        else if (evt0 || evt1)  flag <= 1'b1;
        else if (clr_wr)        flag <= 1'b0;
    end

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (start0 || start1) |=> !ready); // R5
    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_state == CC_WAIT) |-> !(start0 || start1)); // R3
    AST_FLAG_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (evt0 || evt1) |=> flag); // R8
endmodule

// File: rtl/mix_sat.sv
module mix_sat
    import dual_play_pkg::*;
#(
    parameter int         N_CH = 2,
    parameter logic [15:0] AMP = 16'd24576
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_CH-1:0]        play,
    input  logic [N_CH*REG_W-1:0]  vol,
    output logic signed [15:0]     mix_out
);
    localparam int PROD_W = 16 + REG_W + 1;
    localparam int SCL_W  = PROD_W - 16;
    localparam int SUM_W  = SCL_W + $clog2(N_CH) + 1;

    logic signed [SCL_W-1:0] scaled [N_CH];
    logic signed [SUM_W-1:0] sum;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic signed [PROD_W-1:0] prod;
        assign prod = $signed({1'b0, AMP}) * $signed({1'b0, vol[c*REG_W +: REG_W]});
        assign scaled[c] = play[c] ? prod[PROD_W-1:16] : '0;
    end

    always_comb begin
        sum = '0;
        for (int c = 0; c < N_CH; c++) sum = sum + SUM_W'(scaled[c]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          mix_out <= '0;
        else if (sum > SUM_W'(32767))        mix_out <= 16'sh7FFF;
        else if (sum < -SUM_W'(32768))       mix_out <= 16'sh8000;
        else                                 mix_out <= sum[15:0];
    end

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (play == '0) |=> (mix_out == '0)); // R12
endmodule

// File: rtl/dual_play_ctrl.sv
module dual_play_ctrl
    import dual_play_pkg::*;
#(
    parameter int          CH1_PERIOD = 4,
    parameter logic [15:0] AMP        = 16'd24576
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic [3:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        irq,
    output logic [15:0] mix_out
);
    logic [CMD_W-1:0] cmd0, cmd1;
    logic [REG_W-1:0] sen0, sen1, vol0, vol1, rep0, rep1, spd0, spd1;
    ch_state_e        st0, st1;
    logic             evt0, evt1, start0, start1, ready, flag;
    logic             play0, play1;

    assign play0 = (st0 == CH_PLAY);
    assign play1 = (st1 == CH_PLAY);
    assign irq   = flag;

    function automatic logic hit(input logic [3:0] a);
        return bus_we && (bus_addr == a);
    endfunction

    play_chan #(.HAS_SPEED(1'b1), .FIXED_PERIOD(CH1_PERIOD)) u_ch0 (
        .clk(clk), .rst_n(rst_n),
        .wr_cmd(hit(A_CMD0)), .wr_sen(hit(A_SEN0)), .wr_vol(hit(A_VOL0)),
        .wr_rep(hit(A_REP0)), .wr_spd(hit(A_SPD0)), .wdata(bus_wdata),
        .start(start0), .cmd_q(cmd0), .sen_q(sen0), .vol_q(vol0),
        .rep_q(rep0), .spd_q(spd0), .state(st0), .evt(evt0)
    );

    play_chan #(.HAS_SPEED(1'b0), .FIXED_PERIOD(CH1_PERIOD)) u_ch1 (
        .clk(clk), .rst_n(rst_n),
        .wr_cmd(hit(A_CMD1)), .wr_sen(hit(A_SEN1)), .wr_vol(hit(A_VOL1)),
        .wr_rep(hit(A_REP1)), .wr_spd(1'b0), .wdata(bus_wdata),
        .start(start1), .cmd_q(cmd1), .sen_q(sen1), .vol_q(vol1),
        .rep_q(rep1), .spd_q(spd1), .state(st1), .evt(evt1)
    );

    cmd_ctrl u_cc (
        .clk(clk), .rst_n(rst_n),
        .go_wr(hit(A_GO) && bus_wdata[0]), .go_sel(bus_wdata[1]),
        .clr_wr(hit(A_FLAG) && !bus_wdata[0]),
        .cmd0(cmd0), .cmd1(cmd1), .play0(play0), .play1(play1),
        .evt0(evt0), .evt1(evt1), .start0(start0), .start1(start1),
        .ready(ready), .flag(flag)
    );

    mix_sat #(.N_CH(2), .AMP(AMP)) u_mix (
        .clk(clk), .rst_n(rst_n), .play({play1, play0}),
        .vol({vol1, vol0}), .mix_out(mix_out)
    );

    always_comb begin
        unique case (bus_addr)
            A_CMD0:  bus_rdata = {8'h00, cmd0};
            A_SEN0:  bus_rdata = sen0;
            A_VOL0:  bus_rdata = vol0;
            A_REP0:  bus_rdata = rep0;
            A_SPD0:  bus_rdata = spd0;
            A_ST0:   bus_rdata = {14'd0, st0};
            A_CMD1:  bus_rdata = {8'h00, cmd1};
            A_SEN1:  bus_rdata = sen1;
            A_VOL1:  bus_rdata = vol1;
            A_REP1:  bus_rdata = rep1;
            A_SPD1:  bus_rdata = spd1;
            A_ST1:   bus_rdata = {14'd0, st1};
            A_GO:    bus_rdata = {15'd0, ready};
            A_FLAG:  bus_rdata = {15'd0, flag};
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: tb/dual_play_ctrl_tb.sv
module dual_play_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;
    logic [15:0] mix_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    localparam int AMPV = 24576;

    always #4 clk = ~clk;

    dual_play_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .mix_out(mix_out)
    );

    function automatic int scale(input int vol);
        longint p;
        p = longint'(AMPV) * longint'(vol);
        return int'(p >>> 16);
    endfunction

    function automatic int sat16(input int x);
        if (x > 32767) return 32767;
        if (x < -32768) return -32768;
        return x;
    endfunction

    function automatic int play_len(input int s, input int r, input int p);
        return (s + 1) * (r + 1) * p;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        @(negedge clk);
        bus_addr = a;
        #1 v = int'(bus_rdata);
    endtask

    task automatic wait_idle(input logic [3:0] a);
        int v;
        for (int n = 0; n < 5000; n++) begin
            rd(a, v);
            if (v == 1) return;
        end
        check("R7 timeout", v, 1);
    endtask

    initial begin
        #1_600_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int v, cnt, s, r, sp, vl;
        bit mix_seen;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        rd(4'h5, v); check("R1 st0", v, 1);
        rd(4'hD, v); check("R1 st1", v, 1);
        rd(4'hE, v); check("R1 ready", v, 1);
        rd(4'hF, v); check("R1 flag", v, 0);
        check("R1 irq", int'(irq), 0);
        check("R1 mix", int'(mix_out), 0);

        // R4: wrong command code
        wr(4'h0, 16'h0002);
        wr(4'hE, 16'h0001);
        rd(4'h5, v); check("R4 st0", v, 1);
        rd(4'hF, v); check("R4 flag", v, 0);
        rd(4'hE, v); check("R4 ready", v, 1);

        // R2, R3, R5, R8: start channel 1
        wr(4'h8, 16'h0001); wr(4'h9, 16'd49); wr(4'hA, 16'h8000); wr(4'hB, 16'd0);
        rd(4'h9, v); check("R2 sen1", v, 49);
        rd(4'h8, v); check("R2 cmd1", v, 1);
        wr(4'hE, 16'h0003);
        rd(4'hE, v); check("R5 ready low", v, 0);
        rd(4'hE, v); check("R5 ready back", v, 1);
        rd(4'hD, v); check("R3 st1 play", v, 2);
        check("R8 irq start", int'(irq), 1);
        wr(4'hF, 16'h0001);
        rd(4'hF, v); check("R8 write1 keeps", v, 1);
        wr(4'hF, 16'h0000);
        rd(4'hF, v); check("R8 clear", v, 0);

        // R6: retrigger a playing channel
        wr(4'hE, 16'h0003);
        rd(4'hF, v); check("R6 no flag", v, 0);
        rd(4'hD, v); check("R6 still play", v, 2);

        // R12, R10, R11: start channel 0 alongside
        wr(4'h0, 16'h0001); wr(4'h1, 16'd20); wr(4'h2, 16'h8000);
        wr(4'h3, 16'd1); wr(4'h4, 16'd1);
        wr(4'hE, 16'h0001);
        rd(4'h5, v); check("R3 st0 play", v, 2);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R12 mix both", int'($signed(mix_out)), sat16(scale(32768) + scale(32768)));
        wr(4'h2, 16'hFFFF); wr(4'hA, 16'hFFFF);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R10 R12 sat", int'($signed(mix_out)), 32767);
        wr(4'hA, 16'h1000);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R10 vol change", int'($signed(mix_out)), sat16(scale(65535) + scale(4096)));
        wr(4'h4, 16'd3);
        rd(4'h4, v); check("R11 locked", v, 1);
        wait_idle(4'h5);
        wait_idle(4'hD);
        check("R8 irq end", int'(irq), 1);
        wr(4'h4, 16'd3);
        rd(4'h4, v); check("R11 idle write", v, 3);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R12 silent", int'(mix_out), 0);

        // R9: end event coincides with clear write (ch1: 4 samples x 4 cycles)
        wr(4'h9, 16'd1); wr(4'hB, 16'd1);
        wr(4'hE, 16'h0003);
        wr(4'hF, 16'h0000);
        repeat (14) @(posedge clk);
        wr(4'hF, 16'h0000);
        rd(4'hD, v); check("R9 ended", v, 1);
        check("R9 sticky", int'(irq), 1);

        // R7, R12: random playbacks on channel 0
        for (int it = 0; it < 16; it++) begin
            s  = int'($urandom % 5);
            r  = int'($urandom % 3);
            sp = int'($urandom % 3);
            vl = int'($urandom % 65536);
            if (it == 0) begin s = 0; r = 0; sp = 0; end
            wr(4'h1, 16'(s)); wr(4'h3, 16'(r)); wr(4'h4, 16'(sp)); wr(4'h2, 16'(vl));
            wr(4'hE, 16'h0001);
            cnt = 0;
            mix_seen = 1'b0;
            for (int n = 0; n < 2000; n++) begin
                rd(4'h5, v);
                if (v != 2) break;
                cnt++;
                if (cnt == 3) begin
                    mix_seen = 1'b1;
                    check("R12 mix ch0", int'($signed(mix_out)), scale(vl));
                end
            end
            check("R7 length", cnt, play_len(s, r, sp + 1));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule